// File: doc/BRIEF.md
# Hashed Address Generator

The block turns a key of `KEY_W` bits into an index of `IDX_W` bits. For a key that belongs to a programmed set of up to k vectors it returns that vector's own index, a number from 1 to k. For any other key it returns 0. Most of the set sits in a hash memory. The few vectors that collide on a hash address are handled by an external overflow path, whose index enters at `ovf_idx` and is merged into the result.

The key has two parts. The bound part is its upper `BOUND_W` bits and the free part is its lower `FREE_W = KEY_W - BOUND_W` bits. Each bound bit is XORed with one chosen free bit to form the hash address. The hash memory returns a candidate index. That candidate then addresses an auxiliary memory, which holds the free part of the vector stored under that index. If the stored free part equals the incoming one, the candidate is accepted. Because of the XOR pairing, the free part alone is enough to identify the whole key.

Both memories are loaded through simple write ports. One lookup can start on every clock.

Top module: `hash_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `idx_out` becomes 0 and stays 0 for as long as reset is held, whatever `key_in` and `ovf_idx` carry.
- R2: The result for the `key_in` and `ovf_idx` sampled at one rising edge appears on `idx_out` after the third rising edge. A new lookup can be started at every edge.
- R3: Hash address bit i (i = 0 is the LSB) is `key_in[KEY_W-1-i]` XOR `key_in[s_i]`. Here s_i is byte i of `PAIR_SEL` and indexes the free part `key_in[FREE_W-1:0]`. With the defaults, address bit 0 pairs key bit 5 with key bit 0, bit 1 pairs key bit 4 with bit 1, and bit 2 pairs key bit 3 with bit 2.
- R4: A hit occurs when the hash word c at the key's hash address is nonzero and auxiliary word c equals the key's free part. On a hit the hash path contributes c.
- R5: When auxiliary word c differs from the key's free part, the hash path contributes 0.
- R6: When the candidate c is 0, the hash path contributes 0, even if auxiliary word 0 equals the key's free part.
- R7: `idx_out` is the bitwise OR of the hash-path contribution and the `ovf_idx` of the same lookup.
- R8: With the defaults, load the hash words at addresses 0 to 7 with 2,5,1,0,6,7,3,0. Load auxiliary words 1 to 7 with 010,010,010,110,001,011,111. Let the overflow path supply 4 for key 001110 and 0 for every other key. Then all 64 keys map as follows: 000010 gives 1, 010010 gives 2, 001010 gives 3, 001110 gives 4, 000001 gives 5, 111011 gives 6, 010111 gives 7, and every other key gives 0.
- R9: A write with `hash_we` or `aux_we` high at a rising edge stores the data at the given address. Lookups sampled at later edges use the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_in | input | KEY_W | Key to look up, one per cycle |
| ovf_idx | input | IDX_W | Index from the overflow path for the same key |
| hash_we | input | 1 | Hash memory write enable |
| hash_waddr | input | BOUND_W | Hash memory write address |
| hash_wdata | input | IDX_W | Hash memory write data (candidate index) |
| aux_we | input | 1 | Auxiliary memory write enable |
| aux_waddr | input | IDX_W | Auxiliary memory write address (index) |
| aux_wdata | input | FREE_W | Auxiliary memory write data (stored free part) |
| idx_out | output | IDX_W | Matched index, or 0 |

## Verification
The stability property assumes that a key held for consecutive cycles, with neither memory written during the lookups that read them, gives a repeated result. The bench therefore loads each memory image completely before it starts a burst of lookups, and it never writes while a burst is running. The overflow property assumes that `ovf_idx` belongs to the key presented with it. The bench keeps to this by deriving the overflow value from the key in the worked table, and by treating it as a free input in the random rounds. Random keys are half uniform and half built from a stored entry, so that hits, mismatches and empty slots all occur.

// File: rtl/addrgen_pkg.sv
package addrgen_pkg;
  // width of one partner-select field inside the pairing vector
  localparam int SEL_W = 8;
endpackage

// File: rtl/addrgen_scramble.sv
module addrgen_scramble
  import addrgen_pkg::*;
#(
  parameter int KEY_W   = 6,
  parameter int BOUND_W = 3,
  parameter logic [BOUND_W*SEL_W-1:0] PAIR_SEL = '0,
  localparam int FREE_W = KEY_W - BOUND_W
) (
  input  logic [KEY_W-1:0]   key,
  output logic [BOUND_W-1:0] haddr,
  output logic [FREE_W-1:0]  free_part
);
  assign free_part = key[FREE_W-1:0];

  // each address bit: one bound bit XOR its chosen partner in the free part
  for (genvar i = 0; i < BOUND_W; i++) begin : g_bit
    localparam int SEL = int'(PAIR_SEL[i*SEL_W +: SEL_W]);
    assign haddr[i] = key[KEY_W-1-i] ^ free_part[SEL];
  end
endmodule

// File: rtl/addrgen_ram.sv
module addrgen_ram #(
  parameter int AW = 3,
  parameter int DW = 3,
  localparam int DEPTH = 2 ** AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port, output register cleared by reset
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/addrgen_merge.sv
module addrgen_merge #(
  parameter int IDX_W  = 3,
  parameter int FREE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  cand,
  input  logic [FREE_W-1:0] stored_free,
  input  logic [FREE_W-1:0] key_free,
  input  logic [IDX_W-1:0]  ovf,
  output logic [IDX_W-1:0]  idx_out
);
  logic             match;
  logic [IDX_W-1:0] gated;

  always_comb begin
    match = (stored_free == key_free) && (cand != '0);
    gated = match ? cand : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) idx_out <= '0;
    else     idx_out <= gated | ovf;
  end
endmodule

// File: rtl/hash_addr_gen.sv
module hash_addr_gen
  import addrgen_pkg::*;
#(
  parameter int KEY_W   = 6,
  parameter int BOUND_W = 3,
  parameter int IDX_W   = 3,
  parameter logic [BOUND_W*SEL_W-1:0] PAIR_SEL = 24'h02_01_00,
  localparam int FREE_W = KEY_W - BOUND_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [KEY_W-1:0]   key_in,
  input  logic [IDX_W-1:0]   ovf_idx,
  input  logic               hash_we,
  input  logic [BOUND_W-1:0] hash_waddr,
  input  logic [IDX_W-1:0]   hash_wdata,
  input  logic               aux_we,
  input  logic [IDX_W-1:0]   aux_waddr,
  input  logic [FREE_W-1:0]  aux_wdata,
  output logic [IDX_W-1:0]   idx_out
);
  logic [BOUND_W-1:0] haddr;
  logic [FREE_W-1:0]  free_s0, free_s1, free_s2;
  logic [IDX_W-1:0]   cand_s1, cand_s2;
  logic [IDX_W-1:0]   ovf_s1, ovf_s2;
  logic [FREE_W-1:0]  aux_q;

  addrgen_scramble #(
    .KEY_W(KEY_W), .BOUND_W(BOUND_W), .PAIR_SEL(PAIR_SEL)
  ) u_scr (
    .key(key_in), .haddr(haddr), .free_part(free_s0)
  );

  // stage 1: hash memory read gives the candidate index
  addrgen_ram #(.AW(BOUND_W), .DW(IDX_W)) u_hash (
    .clk(clk), .rst(rst), .we(hash_we), .waddr(hash_waddr),
    .wdata(hash_wdata), .raddr(haddr), .rdata(cand_s1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      free_s1 <= '0;
      ovf_s1  <= '0;
    end else begin
      free_s1 <= free_s0;
      ovf_s1  <= ovf_idx;
    end
  end

  // stage 2: candidate addresses the stored free parts
  addrgen_ram #(.AW(IDX_W), .DW(FREE_W)) u_aux (
    .clk(clk), .rst(rst), .we(aux_we), .waddr(aux_waddr),
    .wdata(aux_wdata), .raddr(cand_s1), .rdata(aux_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_s2 <= '0;
      free_s2 <= '0;
      ovf_s2  <= '0;
    end else begin
      cand_s2 <= cand_s1;
      free_s2 <= free_s1;
      ovf_s2  <= ovf_s1;
    end
  end

  // stage 3: compare, gate, merge with overflow, register
  addrgen_merge #(.IDX_W(IDX_W), .FREE_W(FREE_W)) u_merge (
    .clk(clk), .rst(rst), .cand(cand_s2), .stored_free(aux_q),
    .key_free(free_s2), .ovf(ovf_s2), .idx_out(idx_out)
  );
endmodule

// File: rtl/addrgen_chk.sv
module addrgen_chk #(
  parameter int KEY_W = 6,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [KEY_W-1:0] key_in,
  input logic [IDX_W-1:0] ovf_idx,
  input logic             hash_we,
  input logic             aux_we,
  input logic [IDX_W-1:0] idx_out,
  input logic [IDX_W-1:0] cand_s2,
  input logic [IDX_W-1:0] ovf_s2
);
  // edges since reset, saturating
  logic [2:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst)                run_cnt <= '0;
    else if (run_cnt != 3'd7) run_cnt <= run_cnt + 3'd1;
  end

  // R1: output cleared by reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> idx_out == '0);

  // R7: every overflow bit reaches the output three edges later
  p_ovf_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 3'd3) |-> (($past(ovf_idx, 3) & ~idx_out) == '0));

  // R6: an empty candidate with no overflow gives zero
  p_zero_cand_r6: assert property (@(posedge clk) disable iff (rst)
    (cand_s2 == '0 && ovf_s2 == '0) |=> idx_out == '0);

  // R4: without overflow the output is zero or the candidate
  p_hit_value_r4: assert property (@(posedge clk) disable iff (rst)
    (ovf_s2 == '0) |=> (idx_out == '0 || idx_out == $past(cand_s2)));

  // R2: the same lookup twice with no memory change repeats its result
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 3'd5 && $past(key_in, 3) == $past(key_in, 4)
     && $past(ovf_idx, 3) == $past(ovf_idx, 4)
     && !$past(hash_we, 3) && !$past(hash_we, 4)
     && !$past(aux_we, 3) && !$past(aux_we, 4)) |-> $stable(idx_out));
endmodule

bind hash_addr_gen addrgen_chk #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .key_in(key_in), .ovf_idx(ovf_idx),
  .hash_we(hash_we), .aux_we(aux_we), .idx_out(idx_out),
  .cand_s2(cand_s2), .ovf_s2(ovf_s2)
);

// File: tb/tb_hash_addr_gen.sv
`timescale 1ns/1ps
module tb_hash_addr_gen;
  localparam int KW = 6, BW = 3, IW = 3, FW = 3;
  localparam logic [23:0] PSEL = 24'h02_01_00;

  logic clk = 0, rst = 1;
  logic [KW-1:0] key_in = '0;
  logic [IW-1:0] ovf_idx = '0;
  logic hash_we = 0, aux_we = 0;
  logic [BW-1:0] hash_waddr = '0;
  logic [IW-1:0] hash_wdata = '0, aux_waddr = '0;
  logic [FW-1:0] aux_wdata = '0;
  logic [IW-1:0] idx_out;

  hash_addr_gen #(.KEY_W(KW), .BOUND_W(BW), .IDX_W(IW), .PAIR_SEL(PSEL)) dut (
    .clk(clk), .rst(rst), .key_in(key_in), .ovf_idx(ovf_idx),
    .hash_we(hash_we), .hash_waddr(hash_waddr), .hash_wdata(hash_wdata),
    .aux_we(aux_we), .aux_waddr(aux_waddr), .aux_wdata(aux_wdata),
    .idx_out(idx_out));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [IW-1:0] hm [8];
  logic [FW-1:0] am [8];
  logic [KW-1:0] bk [80];
  logic [IW-1:0] bo [80], be [80];
  int bn;
  string btag;

  function automatic logic [BW-1:0] f_addr(logic [KW-1:0] k);
    logic [BW-1:0] a;
    for (int b = 0; b < BW; b++) a[b] = k[KW-1-b] ^ k[PSEL[b*8 +: 8]];
    return a;
  endfunction

  function automatic logic [IW-1:0] f_model(logic [KW-1:0] k, logic [IW-1:0] o);
    logic [IW-1:0] c;
    c = hm[f_addr(k)];
    if (c != '0 && am[c] == k[FW-1:0]) return c | o;
    return o;
  endfunction

  function automatic logic [IW-1:0] f_table(logic [KW-1:0] k);
    case (k)
      6'b000010: return 3'd1;
      6'b010010: return 3'd2;
      6'b001010: return 3'd3;
      6'b001110: return 3'd4;
      6'b000001: return 3'd5;
      6'b111011: return 3'd6;
      6'b010111: return 3'd7;
      default:   return 3'd0;
    endcase
  endfunction

  task automatic check(string req, logic [IW-1:0] act, logic [IW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_hash(logic [BW-1:0] a, logic [IW-1:0] d);
    @(negedge clk); hash_we = 1; hash_waddr = a; hash_wdata = d;
    @(negedge clk); hash_we = 0;
    hm[a] = d;
  endtask

  task automatic wr_aux(logic [IW-1:0] a, logic [FW-1:0] d);
    @(negedge clk); aux_we = 1; aux_waddr = a; aux_wdata = d;
    @(negedge clk); aux_we = 0;
    am[a] = d;
  endtask

  task automatic push(logic [KW-1:0] k, logic [IW-1:0] o, logic [IW-1:0] e);
    bk[bn] = k; bo[bn] = o; be[bn] = e; bn++;
  endtask

  // back-to-back lookups, each result checked three edges after issue
  task automatic run_burst();
    for (int i = 0; i < bn + 3; i++) begin
      @(negedge clk);
      if (i >= 3) check(btag, idx_out, be[i-3]);
      if (i < bn) begin key_in = bk[i]; ovf_idx = bo[i]; end
      else begin key_in = '0; ovf_idx = '0; end
    end
    bn = 0;
  endtask

  task automatic one(string tag, logic [KW-1:0] k, logic [IW-1:0] o);
    btag = tag; bn = 0; push(k, o, f_model(k, o)); run_burst();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R2): actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] hinit [8];
    logic [FW-1:0] ainit [8];
    void'($urandom(32'd4711));
    hinit = '{3'd2, 3'd5, 3'd1, 3'd0, 3'd6, 3'd7, 3'd3, 3'd0};
    ainit = '{3'b000, 3'b010, 3'b010, 3'b010, 3'b110, 3'b001, 3'b011, 3'b111};
    bn = 0;

    // R1: reset with busy inputs
    rst = 1; ovf_idx = 3'd7; key_in = 6'b000010;
    repeat (4) @(negedge clk);
    check("R1", idx_out, 3'd0);
    @(negedge clk); rst = 0; ovf_idx = '0; key_in = '0;

    for (int a = 0; a < 8; a++) wr_hash(a[BW-1:0], hinit[a]);
    for (int a = 0; a < 8; a++) wr_aux(a[IW-1:0], ainit[a]);
    repeat (3) @(negedge clk);

    // R8: exhaustive keys against the registered table
    btag = "R8";
    for (int k = 0; k < 64; k++)
      push(k[KW-1:0], (k == 6'b001110) ? 3'd4 : 3'd0, f_table(k[KW-1:0]));
    run_burst();

    // R2: result must not appear before the third edge
    @(negedge clk); key_in = 6'b000010; ovf_idx = '0;
    @(negedge clk); key_in = '0;
    @(negedge clk); check("R2 early", idx_out, 3'd0);
    @(negedge clk); check("R2", idx_out, 3'd1);

    one("R4", 6'b111011, 3'd0);               // hit on candidate 6
    btag = "R5"; push(6'b010000, 3'd0, 3'd0); run_burst(); // candidate 1, free mismatch
    btag = "R7"; push(6'b000010, 3'b110, 3'd7); push(6'b000000, 3'd5, 3'd5); run_burst();

    // R6: empty slot with aux word 0 matching the free part
    wr_aux(3'd0, 3'b011);
    repeat (3) @(negedge clk);
    btag = "R6"; push(6'b000011, 3'd0, 3'd0); run_burst();

    // R9: new hash word takes effect
    btag = "R9"; push(6'b101110, 3'd0, 3'd0); run_burst();
    wr_hash(3'd3, 3'd4);
    repeat (3) @(negedge clk);
    btag = "R9"; push(6'b101110, 3'd0, 3'd4); run_burst();

    // random rounds: R3 address pairing, R7 merge, back-to-back R2
    for (int round = 0; round < 3; round++) begin
      for (int a = 0; a < 8; a++) wr_hash(a[BW-1:0], IW'($urandom % 8));
      for (int a = 0; a < 8; a++) wr_aux(a[IW-1:0], FW'($urandom % 8));
      repeat (3) @(negedge clk);
      btag = "R3 R7 random";
      for (int n = 0; n < 40; n++) begin
        logic [KW-1:0] k;
        logic [IW-1:0] o;
        if ($urandom % 2 == 0) k = KW'($urandom % 64);
        else begin
          logic [BW-1:0] ha;
          logic [FW-1:0] fp;
          ha = BW'($urandom % 8);
          fp = am[hm[ha]];
          k = {3'b000, fp};
          for (int b = 0; b < BW; b++) k[KW-1-b] = ha[b] ^ fp[PSEL[b*8 +: 8]];
        end
        o = ($urandom % 4 == 0) ? IW'($urandom % 8) : '0;
        push(k, o, f_model(k, o));
      end
      run_burst();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule